// File: doc/BRIEF.md
# Nonvolatile Memory Access Controller

This block gives a CPU indirect access to two on-chip nonvolatile stores through six bus registers. The six registers are control, unlock, data low, data high, address low and address high. A select bit chooses the store. The data store is 256 bytes and can be read and written. The program store is 4096 words of 14 bits and can only be read. Software loads the address and data registers and then sets a start bit in the control register. The hardware performs the operation and clears that start bit when the operation completes.

A read completes in one clock and loads the data registers. A data-store write is guarded twice. The write-enable bit must already be set. The two bus writes just before the start must be 0x55 and then 0xAA to the unlock register. A guarded write runs for a fixed number of cycles set by an internal timer. During those cycles it erases the byte and then programs it. When it finishes it raises a completion flag that only software can clear. If a functional reset arrives while a write is running, an error flag is set and stays set through that reset. A separate power-on reset clears everything.

Top module: `nvm_access_ctrl`

## Requirements
- R1: Register addresses are 0 control, 1 unlock, 2 data low, 3 data high (6 bits, upper bits read 0), 4 address low, 5 address high (4 bits, upper bits read 0). After reset, control reads 0x00. Control bits are: bit0 read start, bit1 write start, bit2 write enable, bit3 write error, bit4 write done, bit7 store select.
- R2: The unlock register holds no state and always reads 0x00.
- R3: Store select (control bit7) picks the data store when 0 and the program store when 1. It is 0 after reset.
- R4: Writing 1 to bit0 starts a read. Bit0 reads 1 for exactly one cycle and is then cleared by hardware. At that same edge the data registers are loaded.
- R5: A program read uses the address {address high, address low}. It returns word = (addr*37 + 0x2A5C) mod 2^14. Bits 7:0 go to data low and bits 13:8 go to data high.
- R6: A data-store read uses only address low and loads only data low. Data high is left unchanged.
- R7: Writing 1 to bit1 starts a write only if all three conditions hold. First, write enable was already 1 before that bus write. Second, the two previous bus writes were 0x55 and then 0xAA to the unlock register. Third, no write is in progress. Otherwise bit1 stays 0 and no memory changes.
- R8: A write start while the program store is selected is refused: bit1 stays 0 and no memory changes.
- R9: An accepted write keeps bit1 at 1 for 64 cycles. A bus write of 0 to bit1 cannot clear it. The byte is erased and then programmed, and it reads back as the new value.
- R10: While a write is in progress, bus writes to the address and data registers are ignored.
- R11: At write completion, bit4 and `done_irq` go to 1. Writing 0 to bit4 clears them. Writing 1 to bit4 never sets them.
- R12: A functional reset (`rst_n` low) during a write sets bit3, and bit3 survives later functional resets. Writing 0 to bit3 clears it. `por_n` low clears all registers including bit3, and sets every data-store byte to 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, synchronous, active low |
| rst_n | input | 1 | Functional reset, synchronous, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| done_irq | output | 1 | Write completion flag |

## Verification
The unlock guard gets the most attention. The bench tries a missing enable, a stray bus write between the two keys, the keys in reversed order, and the program store selected. A design that loosened any of these would show bit1 set and a changed byte. A second write is made while the timer is busy to show that the address and data registers stay frozen. A design that let them through would program the wrong byte or return the wrong value. A functional reset in the middle of a write must leave the error bit set across a further reset, and only power-on may clear it. The program-read result must be split across both data registers, so a design that dropped or shifted the high bits would be caught.

// File: rtl/nvm_pkg.sv
// Shared register addresses, control bit positions, unlock keys and
// unlock state type for the nonvolatile access controller.
package nvm_pkg;
    localparam logic [2:0] RA_CTRL = 3'd0;
    localparam logic [2:0] RA_UNLK = 3'd1;
    localparam logic [2:0] RA_DLO  = 3'd2;
    localparam logic [2:0] RA_DHI  = 3'd3;
    localparam logic [2:0] RA_ALO  = 3'd4;
    localparam logic [2:0] RA_AHI  = 3'd5;

    localparam int B_RD   = 0;
    localparam int B_WR   = 1;
    localparam int B_WEN  = 2;
    localparam int B_ERR  = 3;
    localparam int B_DONE = 4;
    localparam int B_SEL  = 7;

    localparam logic [7:0] KEY_FIRST  = 8'h55;
    localparam logic [7:0] KEY_SECOND = 8'hAA;

    typedef enum logic [1:0] {
        UL_IDLE = 2'd0,
        UL_HALF = 2'd1,
        UL_OPEN = 2'd2
    } unlock_e;
endpackage

// File: rtl/nvm_unlock.sv
// Unlock sequence detector.
// Tracks bus writes only and ignores idle cycles. "armed" is high when
// the two most recent bus writes were the first key and then the second
// key to the unlock register. Any further bus write drops "armed".
// Assumes: hit is qualified by the caller as a write to the unlock register.
module nvm_unlock (
    input  logic       clk,
    input  logic       run_n,
    input  logic       bus_wr,
    input  logic       hit,
    input  logic [7:0] wdata,
    output logic       armed
);
    import nvm_pkg::*;

    unlock_e st_q;

    // Advance the key detector on every bus write.
    always_ff @(posedge clk) begin
        if (!run_n) begin
            st_q <= UL_IDLE;
        end else if (bus_wr) begin
            if (hit && wdata == KEY_FIRST)
                st_q <= UL_HALF;
            else if (hit && wdata == KEY_SECOND && st_q == UL_HALF)
                st_q <= UL_OPEN;
            else
                st_q <= UL_IDLE;
        end
    end

    assign armed = (st_q == UL_OPEN);

    // R7
    armed_after_key_chk: assert property (@(posedge clk) disable iff (!run_n)
        $rose(armed) |-> $past(bus_wr && hit && wdata == KEY_SECOND));
endmodule

// File: rtl/nvm_wr_timer.sv
// Write timer.
// Runs for CYCLES clocks after start. It pulses "erase" at the midpoint
// and "finish" on the last cycle, where the byte is programmed.
// Assumes: CYCLES >= 4, and start is only asserted while not busy.
module nvm_wr_timer #(
    parameter int CYCLES = 64
) (
    input  logic clk,
    input  logic run_n,
    input  logic start,
    output logic busy,
    output logic erase,
    output logic finish
);
    localparam int CNT_W = $clog2(CYCLES);
    localparam logic [CNT_W-1:0] LAST     = CNT_W'(CYCLES - 1);
    localparam logic [CNT_W-1:0] ERASE_AT = CNT_W'(CYCLES / 2 - 1);

    logic [CNT_W-1:0] cnt_q;

    // Count the cycles of a running write and stop after the last one.
    always_ff @(posedge clk) begin
        if (!run_n) begin
            busy  <= 1'b0;
            cnt_q <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            cnt_q <= '0;
        end else if (busy) begin
            if (cnt_q == LAST) begin
                busy  <= 1'b0;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign erase  = busy && (cnt_q == ERASE_AT);
    assign finish = busy && (cnt_q == LAST);

    // R9
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!run_n)
        !busy |-> cnt_q == '0);
    // R9
    finish_ends_chk: assert property (@(posedge clk) disable iff (!run_n)
        finish |=> !busy);
endmodule

// File: rtl/nvm_data_store.sv
// Behavioural byte-wide data store.
// An erase sets the addressed byte to 0xFF. A commit stores the new
// byte. Reads are combinational. Power-on reset erases every byte.
// Assumes: erase and commit never occur in the same cycle.
module nvm_data_store #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          erase,
    input  logic          commit,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];

    // Apply power-on erase, erase step and program step.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (erase) begin
            mem[addr] <= 8'hFF;
        end else if (commit) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];

    // R9
    program_on_erased_chk: assert property (@(posedge clk) disable iff (!por_n)
        commit |-> mem[addr] == 8'hFF);
endmodule

// File: rtl/nvm_prog_rom.sv
// Read-only program store.
// The contents are computed from the address as
// word = addr*MULT + SEED, truncated to DW bits, so no storage array
// is needed.
// Assumes: DW >= AW.
module nvm_prog_rom #(
    parameter int          AW   = 12,
    parameter int          DW   = 14,
    parameter int          MULT = 37,
    parameter logic [DW-1:0] SEED = 14'h2A5C
) (
    input  logic [AW-1:0] addr,
    output logic [DW-1:0] word
);
    logic [DW-1:0] a_ext;

    // Produce the stored word for the given address.
    always_comb begin
        a_ext = DW'(addr);
        word  = a_ext * DW'(MULT) + SEED;
    end
endmodule

// File: rtl/nvm_access_ctrl.sv
// Nonvolatile memory access controller, top level.
// Holds the bus register file, starts reads and guarded writes, and
// keeps the write error and completion flags.
// Assumes: at most one bus write per cycle. rst_n is a functional reset
// and por_n is the power-on reset. Both are synchronous and active low.
module nvm_access_ctrl #(
    parameter int          DATA_AW   = 8,
    parameter int          PROG_AW   = 12,
    parameter int          PROG_DW   = 14,
    parameter int          WR_CYCLES = 64,
    parameter int          PROG_MULT = 37,
    parameter logic [13:0] PROG_SEED = 14'h2A5C
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic [2:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       done_irq
);
    import nvm_pkg::*;

    localparam int AHI_W = PROG_AW - 8;
    localparam int DHI_W = PROG_DW - 8;

    logic             run_n;
    logic             wr_ctrl, wr_unlk, wr_dlo, wr_dhi, wr_alo, wr_ahi;
    logic             sel_prog_q, wr_en_q, err_q, done_q, rd_go_q;
    logic [7:0]       alo_q, dlo_q;
    logic [AHI_W-1:0] ahi_q;
    logic [DHI_W-1:0] dhi_q;
    logic             wr_busy, wr_erase, wr_finish, armed;
    logic             rd_start, wr_start;
    logic [7:0]       store_rdata;
    logic [PROG_DW-1:0] prog_word;

    assign run_n   = rst_n & por_n;
    assign wr_ctrl = bus_wr && bus_addr == RA_CTRL;
    assign wr_unlk = bus_wr && bus_addr == RA_UNLK;
    assign wr_dlo  = bus_wr && bus_addr == RA_DLO;
    assign wr_dhi  = bus_wr && bus_addr == RA_DHI;
    assign wr_alo  = bus_wr && bus_addr == RA_ALO;
    assign wr_ahi  = bus_wr && bus_addr == RA_AHI;

    assign rd_start = wr_ctrl && bus_wdata[B_RD] && !wr_busy && !rd_go_q;
    assign wr_start = wr_ctrl && bus_wdata[B_WR] && armed && wr_en_q
                      && !sel_prog_q && !wr_busy;

    nvm_unlock u_unlock (
        .clk   (clk),
        .run_n (run_n),
        .bus_wr(bus_wr),
        .hit   (wr_unlk),
        .wdata (bus_wdata),
        .armed (armed)
    );

    nvm_wr_timer #(.CYCLES(WR_CYCLES)) u_timer (
        .clk   (clk),
        .run_n (run_n),
        .start (wr_start),
        .busy  (wr_busy),
        .erase (wr_erase),
        .finish(wr_finish)
    );

    nvm_data_store #(.AW(DATA_AW)) u_dstore (
        .clk   (clk),
        .por_n (por_n),
        .erase (wr_erase),
        .commit(wr_finish),
        .addr  (alo_q[DATA_AW-1:0]),
        .wdata (dlo_q),
        .rdata (store_rdata)
    );

    nvm_prog_rom #(.AW(PROG_AW), .DW(PROG_DW), .MULT(PROG_MULT),
                   .SEED(PROG_SEED)) u_prom (
        .addr({ahi_q, alo_q}),
        .word(prog_word)
    );

    // Control bits: store select, write enable, read start, done flag.
    always_ff @(posedge clk) begin
        if (!run_n) begin
            sel_prog_q <= 1'b0;
            wr_en_q    <= 1'b0;
            rd_go_q    <= 1'b0;
            done_q     <= 1'b0;
        end else begin
            if (wr_ctrl && !wr_busy) sel_prog_q <= bus_wdata[B_SEL];
            if (wr_ctrl) wr_en_q <= bus_wdata[B_WEN];
            if (rd_go_q) rd_go_q <= 1'b0;
            else if (rd_start) rd_go_q <= 1'b1;
            if (wr_finish) done_q <= 1'b1;
            else if (wr_ctrl && !bus_wdata[B_DONE]) done_q <= 1'b0;
        end
    end

    // Error flag: set by a functional reset that cuts a write short.
    always_ff @(posedge clk) begin
        if (!por_n) err_q <= 1'b0;
        else if (!rst_n) err_q <= err_q | wr_busy;
        else if (wr_ctrl && !bus_wdata[B_ERR]) err_q <= 1'b0;
    end

    // Address registers: loaded from the bus unless a write is in progress.
    always_ff @(posedge clk) begin
        if (!run_n) begin
            alo_q <= '0;
            ahi_q <= '0;
        end else if (!wr_busy) begin
            if (wr_alo) alo_q <= bus_wdata;
            if (wr_ahi) ahi_q <= bus_wdata[AHI_W-1:0];
        end
    end

    // Data registers: loaded by a finished read, otherwise from the bus when idle.
    always_ff @(posedge clk) begin
        if (!run_n) begin
            dlo_q <= '0;
            dhi_q <= '0;
        end else if (rd_go_q) begin
            if (sel_prog_q) begin
                dlo_q <= prog_word[7:0];
                dhi_q <= prog_word[PROG_DW-1:8];
            end else begin
                dlo_q <= store_rdata;
            end
        end else if (!wr_busy) begin
            if (wr_dlo) dlo_q <= bus_wdata;
            if (wr_dhi) dhi_q <= bus_wdata[DHI_W-1:0];
        end
    end

    // Register read multiplexer.
    always_comb begin
        case (bus_addr)
            RA_CTRL: bus_rdata = {sel_prog_q, 2'b00, done_q, err_q,
                                  wr_en_q, wr_busy, rd_go_q};
            RA_DLO:  bus_rdata = dlo_q;
            RA_DHI:  bus_rdata = 8'(dhi_q);
            RA_ALO:  bus_rdata = alo_q;
            RA_AHI:  bus_rdata = 8'(ahi_q);
            default: bus_rdata = 8'h00;
        endcase
    end

    assign done_irq = done_q;

    // R4
    rd_one_cycle_chk: assert property (@(posedge clk) disable iff (!run_n)
        rd_go_q |=> !rd_go_q);
    // R7
    wr_needs_en_chk: assert property (@(posedge clk) disable iff (!run_n)
        $rose(wr_busy) |-> $past(wr_en_q));
    // R8
    no_prog_write_chk: assert property (@(posedge clk) disable iff (!run_n)
        wr_busy |-> !sel_prog_q);
    // R10
    addr_frozen_chk: assert property (@(posedge clk) disable iff (!run_n)
        (wr_busy && $past(wr_busy)) |-> ($stable(alo_q) && $stable(dlo_q)));
    // R12
    err_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!rst_n && wr_busy) |=> err_q);
    // R2
    unlock_reads_zero_chk: assert property (@(posedge clk) disable iff (!run_n)
        (bus_addr == RA_UNLK) |-> bus_rdata == 8'h00);
endmodule

// File: tb/sim_nvm_access_ctrl.sv
`timescale 1ns/1ps
module sim_nvm_access_ctrl;
    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       done_irq;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    nvm_access_ctrl u0 (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .done_irq(done_irq)
    );

    // Vector fields: {is_write, addr[2:0], data_or_expected[7:0], req[3:0]}.
    localparam int NV = 22;
    localparam logic [15:0] VEC [NV] = '{
        {1'b0, 3'd0, 8'h00, 4'd1},   // R1 control after reset
        {1'b1, 3'd1, 8'h37, 4'd2},
        {1'b0, 3'd1, 8'h00, 4'd2},   // R2 unlock reads zero
        {1'b1, 3'd4, 8'h12, 4'd1},
        {1'b0, 3'd4, 8'h12, 4'd1},
        {1'b1, 3'd5, 8'hFB, 4'd1},
        {1'b0, 3'd5, 8'h0B, 4'd1},   // R1 address high is 4 bits
        {1'b1, 3'd2, 8'h9C, 4'd1},
        {1'b0, 3'd2, 8'h9C, 4'd1},
        {1'b1, 3'd3, 8'hFF, 4'd1},
        {1'b0, 3'd3, 8'h3F, 4'd1},   // R1 data high is 6 bits
        {1'b1, 3'd0, 8'h80, 4'd3},
        {1'b0, 3'd0, 8'h80, 4'd3},   // R3 select program store
        {1'b1, 3'd0, 8'h81, 4'd4},
        {1'b0, 3'd0, 8'h81, 4'd4},   // R4 read start visible one cycle
        {1'b0, 3'd0, 8'h80, 4'd4},   // R4 cleared by hardware
        {1'b0, 3'd2, 8'hF6, 4'd5},   // R5 word(0xB12)=0x03F6
        {1'b0, 3'd3, 8'h03, 4'd5},
        {1'b1, 3'd0, 8'h01, 4'd6},
        {1'b0, 3'd0, 8'h01, 4'd3},   // R3 back to data store
        {1'b0, 3'd2, 8'hFF, 4'd6},   // R6 erased byte at 0x12
        {1'b0, 3'd3, 8'h03, 4'd6}    // R6 data high untouched
    };

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic start_write(input logic [7:0] a, input logic [7:0] d);
        bus_write(3'd4, a);
        bus_write(3'd2, d);
        bus_write(3'd0, 8'h04);
        bus_write(3'd1, 8'h55);
        bus_write(3'd1, 8'hAA);
        bus_write(3'd0, 8'h06);
    endtask

    task automatic wait_idle(output int n);
        logic [7:0] v;
        n = 0;
        for (int k = 0; k < 1000; k++) begin
            bus_read(3'd0, v);
            if (!v[1]) break;
            n++;
        end
    endtask

    task automatic read_byte(input logic [7:0] a, output logic [7:0] v);
        logic [7:0] dummy;
        bus_write(3'd4, a);
        bus_write(3'd0, 8'h01);
        bus_read(3'd0, dummy);
        bus_read(3'd2, v);
    endtask

    task automatic finish_run;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #500000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        int n;
        repeat (3) @(negedge clk);
        por_n = 1'b1; rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][15]) begin
                bus_write(VEC[i][14:12], VEC[i][11:4]);
            end else begin
                bus_read(VEC[i][14:12], v);
                check($sformatf("R%0d vec%0d", VEC[i][3:0], i), v, VEC[i][11:4]);
            end
        end

        // R9 guarded write, duration and readback; R11 completion flag
        start_write(8'h12, 8'h5A);
        wait_idle(n);
        check("R9 busy cycles", 8'(n), 8'd64);
        bus_read(3'd0, v);
        check("R11 done bit set", v, 8'h14);
        check("R11 done_irq set", {7'd0, done_irq}, 8'h01);
        bus_write(3'd0, 8'h14);
        bus_read(3'd0, v);
        check("R11 writing 1 keeps flag", v, 8'h14);
        bus_write(3'd0, 8'h04);
        bus_read(3'd0, v);
        check("R11 cleared by software", {v[7:1], done_irq}, 8'h04);
        bus_write(3'd0, 8'h14);
        bus_read(3'd0, v);
        check("R11 software cannot set", v, 8'h04);
        read_byte(8'h12, v);
        check("R9 readback", v, 8'h5A);

        // R7 no prior write enable
        bus_write(3'd0, 8'h00);
        bus_write(3'd1, 8'h55);
        bus_write(3'd1, 8'hAA);
        bus_write(3'd0, 8'h06);
        bus_read(3'd0, v);
        check("R7 enable not set", v, 8'h04);
        // R7 stray write between keys
        bus_write(3'd1, 8'h55);
        bus_write(3'd2, 8'h66);
        bus_write(3'd1, 8'hAA);
        bus_write(3'd0, 8'h06);
        bus_read(3'd0, v);
        check("R7 broken sequence", v, 8'h04);
        // R7 keys reversed
        bus_write(3'd1, 8'hAA);
        bus_write(3'd1, 8'h55);
        bus_write(3'd0, 8'h06);
        bus_read(3'd0, v);
        check("R7 reversed keys", v, 8'h04);
        read_byte(8'h12, v);
        check("R7 memory unchanged", v, 8'h5A);

        // R8 program store selected
        bus_write(3'd4, 8'h12);
        bus_write(3'd2, 8'h00);
        bus_write(3'd0, 8'h84);
        bus_write(3'd1, 8'h55);
        bus_write(3'd1, 8'hAA);
        bus_write(3'd0, 8'h86);
        bus_read(3'd0, v);
        check("R8 write refused", v, 8'h84);
        read_byte(8'h12, v);
        check("R8 memory unchanged", v, 8'h5A);

        // R10 register writes ignored while busy; R9 start bit not clearable
        start_write(8'h20, 8'h33);
        bus_write(3'd4, 8'h99);
        bus_write(3'd2, 8'h77);
        bus_write(3'd5, 8'h05);
        bus_write(3'd0, 8'h04);
        bus_read(3'd0, v);
        check("R9 start bit held", v, 8'h06);
        wait_idle(n);
        bus_read(3'd4, v);
        check("R10 address low frozen", v, 8'h20);
        bus_read(3'd2, v);
        check("R10 data low frozen", v, 8'h33);
        bus_read(3'd5, v);
        check("R10 address high frozen", v, 8'h0B);
        read_byte(8'h20, v);
        check("R10 intended byte written", v, 8'h33);
        read_byte(8'h99, v);
        check("R10 other byte untouched", v, 8'hFF);

        // R12 functional reset mid-write
        start_write(8'h40, 8'h11);
        repeat (10) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        bus_read(3'd0, v);
        check("R12 error flag set", v, 8'h08);
        check("R12 no done after abort", {7'd0, done_irq}, 8'h00);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        bus_read(3'd0, v);
        check("R12 flag survives reset", v, 8'h08);
        bus_write(3'd0, 8'h00);
        bus_read(3'd0, v);
        check("R12 cleared by software", v, 8'h00);

        // R12 power-on clears flag and erases store
        start_write(8'h40, 8'h22);
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); por_n = 1'b0;
        @(negedge clk); por_n = 1'b1;
        bus_read(3'd0, v);
        check("R12 power-on clears flag", v, 8'h00);
        read_byte(8'h12, v);
        check("R12 power-on erases store", v, 8'hFF);

        finish_run();
    end
endmodule